// File: doc/BRIEF.md
# Two-Wire Bus Recovery Pulse Generator

This block frees a two-wire serial bus whose data line is being held low by a slave device that lost track of a transfer. Software writes a one to a self-clearing trigger bit, and the block then drives exactly sixteen clock pulses on the serial clock line. Each pulse gives the stuck slave one more clock edge with which to finish shifting out its byte and release the data line.

The clock output is open-drain style. It is released (high) while idle, pulled low for each low phase, and released again for each high phase. Every pulse is a low phase followed by a high phase. Two 7-bit configuration fields set the phase widths, counted in oscillator (core clock) cycles: a field value X gives a phase of 8·X + 16 cycles. A field is read at the moment its phase begins. The block reports a busy level for the whole burst and a one-cycle done strobe when the burst ends. The interrupt logic uses the done strobe to set its reset-done cause.

Top module: `busclr_gen`

## Requirements
- R1: After synchronous reset the clock output is released (`scl_pull_low` = 0), `busy` is 0 and `done` is 0.
- R2: When `trig_wr` = 1 with `trig_val` = 1 while `busy` = 0, the next clock cycle shows `busy` = 1 and `scl_pull_low` = 1, which starts the first low phase.
- R3: A burst holds exactly 16 pulses. Each pulse is one low phase followed by one high phase.
- R4: Each low phase keeps `scl_pull_low` = 1 for exactly 8·L + 16 cycles, where L is `lo_width_cfg` (L = 0x37 gives 456 cycles, L = 0x7F gives 1032 cycles).
- R5: Each high phase keeps `scl_pull_low` = 0 with `busy` = 1 for exactly 8·H + 16 cycles, where H is `hi_width_cfg` (H = 0x2D gives 376 cycles).
- R6: In the cycle right after the 16th high phase, `done` = 1 for exactly one cycle, `busy` = 0 and the clock stays released. The trigger is then clear and idle.
- R7: A trigger write while `busy` = 1 is ignored. The running burst keeps its 16 pulses, and no new burst follows it.
- R8: A write with `trig_val` = 0 starts nothing. `busy` stays 0 and the clock stays released.
- R9: A width field is sampled when its phase starts. A change made during a phase affects only phases that begin later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all phase widths count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| trig_wr | input | 1 | Write strobe for the trigger bit |
| trig_val | input | 1 | Value written to the trigger bit; 1 requests a burst |
| hi_width_cfg | input | 7 | High-phase width field H |
| lo_width_cfg | input | 7 | Low-phase width field L |
| scl_pull_low | output | 1 | 1 pulls the serial clock line low; 0 releases it |
| busy | output | 1 | High for the whole burst |
| done | output | 1 | One-cycle strobe after the last high phase |

## Verification
Bursts run with both fields at zero, with unequal small fields, with the register default values and with the largest low field. This shows that the low and high widths follow their own fields and that the 8·X + 16 scale holds from the smallest value to the largest. A field change placed inside the first low phase separates per-phase sampling from sampling once at the trigger and from tracking the live value. A second trigger written mid-burst, and a write of zero while idle, show that neither start nor restart happens outside the one allowed case.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

    // Width of each phase-width configuration field.
    localparam int CFG_W = 7;
    // Phase width scale: width = (X + 1) * UNIT + UNIT.
    localparam int UNIT = 8;
    // Largest phase length in cycles and the counter width it needs.
    localparam int MAX_LEN = ((1 << CFG_W)) * UNIT + UNIT;
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [LEN_W-1:0] len_t;

    // Phase currently driven on the clock line.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Request from the sequencer to the phase timer.
    typedef struct packed {
        logic load;
        len_t len;
    } timer_req_t;

    // Cycle length of one phase for a configuration value.
    function automatic len_t phase_len(cfg_t x);
        return (len_t'(x) + len_t'(1)) * len_t'(UNIT) + len_t'(UNIT);
    endfunction

endpackage

// File: rtl/busclr_phase_timer.sv
module busclr_phase_timer
    import busclr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  timer_req_t req,
    output logic       expire
);

    len_t remain_q;

    // A phase of N cycles loads N-1 and ends in the cycle where zero is reached.
    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (req.load) begin
            remain_q <= req.len - len_t'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - len_t'(1);
        end
    end

    assign expire = (remain_q == '0);

endmodule

// File: rtl/busclr_pulse_counter.sv
module busclr_pulse_counter #(
    parameter int PULSE_COUNT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CNT_W = (PULSE_COUNT > 1) ? $clog2(PULSE_COUNT) : 1;

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign last = (count_q == CNT_W'(PULSE_COUNT - 1));

endmodule

// File: rtl/busclr_seq.sv
module busclr_seq
    import busclr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       expire,
    input  logic       last_pulse,
    input  cfg_t       hi_cfg,
    input  cfg_t       lo_cfg,
    output timer_req_t treq,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output phase_e     phase,
    output logic       done_pulse
);

    phase_e phase_q, phase_d;
    logic   done_q, done_d;

    always_comb begin
        phase_d  = phase_q;
        done_d   = 1'b0;
        treq     = '{load: 1'b0, len: '0};
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_req) begin
                    phase_d  = PH_LOW;
                    treq     = '{load: 1'b1, len: phase_len(lo_cfg)};
                    cnt_clr  = 1'b1;
                end
            end
            PH_LOW: begin
                if (expire) begin
                    phase_d = PH_HIGH;
                    treq    = '{load: 1'b1, len: phase_len(hi_cfg)};
                end
            end
            PH_HIGH: begin
                if (expire) begin
                    if (last_pulse) begin
                        phase_d = PH_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        phase_d = PH_LOW;
                        treq    = '{load: 1'b1, len: phase_len(lo_cfg)};
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= done_d;
        end
    end

    assign phase      = phase_q;
    assign done_pulse = done_q;

endmodule

// File: rtl/busclr_gen.sv
module busclr_gen
    import busclr_pkg::*;
#(
    parameter int PULSE_COUNT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_wr,
    input  logic             trig_val,
    input  logic [CFG_W-1:0] hi_width_cfg,
    input  logic [CFG_W-1:0] lo_width_cfg,
    output logic             scl_pull_low,
    output logic             busy,
    output logic             done
);

    timer_req_t treq;
    phase_e     phase;
    logic       expire;
    logic       last_pulse;
    logic       cnt_clr;
    logic       cnt_inc;
    logic       start_req;

    // The trigger bit is only honoured when idle; it never holds a value.
    assign start_req = trig_wr && trig_val && (phase == PH_IDLE);

    busclr_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .expire     (expire),
        .last_pulse (last_pulse),
        .hi_cfg     (hi_width_cfg),
        .lo_cfg     (lo_width_cfg),
        .treq       (treq),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .phase      (phase),
        .done_pulse (done)
    );

    busclr_phase_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .req    (treq),
        .expire (expire)
    );

    busclr_pulse_counter #(
        .PULSE_COUNT (PULSE_COUNT)
    ) u_count (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .last (last_pulse)
    );

    assign scl_pull_low = (phase == PH_LOW);
    assign busy         = (phase != PH_IDLE);

endmodule

// File: rtl/busclr_gen_chk.sv
module busclr_gen_chk #(
    parameter int PULSE_COUNT = 16
) (
    input logic clk,
    input logic rst,
    input logic trig_wr,
    input logic trig_val,
    input logic scl_pull_low,
    input logic busy,
    input logic done
);

    localparam int PC_W = $clog2(PULSE_COUNT + 1) + 1;

    logic [PC_W-1:0] low_starts;
    logic            prev_low;

    // Count low-phase starts inside the current burst.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_starts <= '0;
            prev_low   <= 1'b0;
        end else begin
            prev_low <= scl_pull_low;
            if (!busy) begin
                low_starts <= '0;
            end else if (scl_pull_low && !prev_low) begin
                low_starts <= low_starts + PC_W'(1);
            end
        end
    end

    p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !scl_pull_low);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && trig_wr && trig_val) |=> (busy && scl_pull_low));

    p_pulse_count_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (low_starts == PC_W'(PULSE_COUNT)));

    p_done_end_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && trig_wr && trig_val) |=> (busy || done));

    p_no_start_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(trig_wr && trig_val)) |=> !busy);

endmodule

bind busclr_gen busclr_gen_chk #(
    .PULSE_COUNT (PULSE_COUNT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .trig_wr      (trig_wr),
    .trig_val     (trig_val),
    .scl_pull_low (scl_pull_low),
    .busy         (busy),
    .done         (done)
);

// File: tb/busclr_gen_test.sv
module busclr_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig_wr = 1'b0;
    logic       trig_val = 1'b0;
    logic [6:0] hi_cfg = 7'd0;
    logic [6:0] lo_cfg = 7'd0;
    logic       scl_pull_low;
    logic       busy;
    logic       done;

    int checks = 0;
    int errors = 0;
    int lo_len[32];
    int hi_len[32];
    int npulse;
    logic end_done;

    busclr_gen uut (
        .clk          (clk),
        .rst          (rst),
        .trig_wr      (trig_wr),
        .trig_val     (trig_val),
        .hi_width_cfg (hi_cfg),
        .lo_width_cfg (lo_cfg),
        .scl_pull_low (scl_pull_low),
        .busy         (busy),
        .done         (done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic kick();
        @(negedge clk);
        trig_wr = 1'b1; trig_val = 1'b1;
        @(negedge clk);
        trig_wr = 1'b0; trig_val = 1'b0;
    endtask

    // Called at the first negedge after the trigger was taken.
    task automatic collect();
        npulse = 0;
        while (busy && npulse < 32) begin
            int len;
            len = 0;
            while (scl_pull_low && len < 5000) begin
                len++;
                @(negedge clk);
            end
            lo_len[npulse] = len;
            len = 0;
            while (!scl_pull_low && busy && len < 5000) begin
                len++;
                @(negedge clk);
            end
            hi_len[npulse] = len;
            npulse++;
        end
        end_done = done;
    endtask

    task automatic burst_check(input int exp_lo, input int exp_hi, input int from);
        int bad_lo;
        int bad_hi;
        bad_lo = -1;
        bad_hi = -1;
        check(npulse == 16, "R3", "pulse count", npulse, 16);
        for (int i = from; i < npulse && i < 32; i++) begin
            if (bad_lo < 0 && lo_len[i] != exp_lo) bad_lo = i;
            if (bad_hi < 0 && hi_len[i] != exp_hi) bad_hi = i;
        end
        check(bad_lo < 0, "R4", "low width", (bad_lo < 0) ? exp_lo : lo_len[bad_lo], exp_lo);
        check(bad_hi < 0, "R5", "high width", (bad_hi < 0) ? exp_hi : hi_len[bad_hi], exp_hi);
        check(end_done == 1'b1, "R6", "done after last high", int'(end_done), 1);
        check(!busy && !scl_pull_low, "R6", "idle and released at done",
              int'({busy, scl_pull_low}), 0);
        @(negedge clk);
        check(done == 1'b0, "R6", "done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        check(scl_pull_low == 1'b0, "R1", "clock released", int'(scl_pull_low), 0);
        check(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done at reset", int'(done), 0);
    endtask

    task automatic t_burst(input int h, input int l);
        hi_cfg = 7'(h);
        lo_cfg = 7'(l);
        kick();
        check(busy && scl_pull_low, "R2", "start of burst", int'({busy, scl_pull_low}), 3);
        collect();
        burst_check(8 * l + 16, 8 * h + 16, 0);
    endtask

    task automatic t_zero_write();
        @(negedge clk);
        trig_wr = 1'b1; trig_val = 1'b0;
        @(negedge clk);
        trig_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(!busy && !scl_pull_low, "R8", "zero write started burst",
                  int'({busy, scl_pull_low}), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_busy_write();
        hi_cfg = 7'd0;
        lo_cfg = 7'd0;
        kick();
        fork
            collect();
            begin
                repeat (40) @(negedge clk);
                trig_wr = 1'b1; trig_val = 1'b1;
                @(negedge clk);
                trig_wr = 1'b0; trig_val = 1'b0;
            end
        join
        burst_check(16, 16, 0);
        for (int i = 0; i < 5; i++) begin
            check(!busy, "R7", "no restart after ignored write", int'(busy), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_midphase();
        hi_cfg = 7'd0;
        lo_cfg = 7'd0;
        kick();
        fork
            collect();
            begin
                repeat (4) @(negedge clk);
                hi_cfg = 7'd2;
                lo_cfg = 7'd1;
            end
        join
        check(lo_len[0] == 16, "R9", "running low phase kept old width", lo_len[0], 16);
        check(hi_len[0] == 32, "R9", "next high phase uses new width", hi_len[0], 32);
        check(lo_len[1] == 24, "R9", "next low phase uses new width", lo_len[1], 24);
        burst_check(24, 32, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_burst(0, 0);
        t_burst(3, 1);
        t_zero_write();
        t_busy_write();
        t_midphase();
        t_burst(7'h2D, 7'h37);
        t_burst(0, 7'h7F);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule